// File: doc/BRIEF.md
# Multi-Mode Parallel Port Register Decoder

This block is the host-facing register file of a PC-style parallel port that works in several modes. A narrow I/O bus reaches it. That bus carries a chip select, a DMA address-enable, two address banks with eight slots each, separate read and write strobes, and an 8-bit data bus. A 3-bit mode field lives in the extended control register, and that field decides which register or transfer port each access reaches. The extended control register can be reached only through the upper bank. After reset the block is a plain output-only printer port. The only way into the bidirectional, EPP, ECP, FIFO, test and configuration modes is a write to that register.

The block holds the data latch, a sampled status byte, the control register, the extended control register and configuration register B. Configuration register A is a read-only constant. Accesses that land on a FIFO or an EPP port are not stored here. They go to a neighbouring block as one-cycle read or write pulses with a 3-bit port code, and that block also returns the read data for those ports. The block also drives the printer data bus, its output enable and the direction indicator.

Top module: `pport_regdec`

## Requirements
- R1: After reset the mode is 000, the data latch is 0x00, the control bits are 0, `pd_dir` is 0 and `pd_oe` is 1. The control register then reads 0xC0 and the extended control register reads 0x00.
- R2: An access is decoded only while `cs_n` is 0 and `aen` is 0. Outside that window no register changes, no transfer pulse is issued and `rdata` is 0xFF. `rdata` is also 0xFF whenever `rd_n` is 1.
- R3: Upper-bank slot 2 is the extended control register in every mode. It is 8 bits, read/write, and bits [7:5] are the mode field, output on `port_mode`.
- R4: Lower-bank slot 0 is the data latch in modes 000 and 001. A write sets the latch, which drives `pd_out`. A read returns the latch, except when `pd_dir` is 1, in which case it returns `pd_in`.
- R5: Lower-bank slot 1 is a read-only status byte in every mode. The printer inputs are sampled once per clock, and the byte is {~busy, ack_n, pe, slct, err_n, 3'b111} from bit 7 down. Writes to it are ignored.
- R6: Lower-bank slot 2 is the control register in every mode. Bit 5 is the direction bit, bit 4 is stored, and bits [3:0] drive `line_ctl`. Bits [7:6] read as 1.
- R7: FIFO routing uses these port codes: 1 = ECP command, 2 = plain FIFO, 3 = ECP data, 4 = test FIFO. In mode 011, a write to lower slot 0 issues code 1 and a read of that slot is undefined. Upper slot 0 carries code 2 in mode 010, where it is write-only. It carries code 3 in mode 011 and code 4 in mode 110, where it can be read and written.
- R8: In mode 100, lower slot 3 is the EPP address port (code 5) and lower slots 4 to 7 are the EPP data port (code 6). Both can be read and written, and reads return `xfer_rdata`.
- R9: In mode 111, upper slot 0 reads the constant parameter `CFGA_VALUE` (0x10 by default) and writes to it are ignored. Upper slot 1 is configuration register B, which is 8 bits, read/write, and resets to 0x00.
- R10: Any slot not defined in the current mode reads 0xFF, ignores writes and issues no pulse.
- R11: `pd_dir` is 1 (input) only when the mode is neither 000 nor 010 and control bit 5 is 1. `pd_oe` is always the inverse of `pd_dir`.
- R12: A transfer pulse lasts exactly one cycle, in the cycle where the strobe is first seen low. Holding the strobe low gives no further pulse. `xfer_code` is 0 when no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| aen | input | 1 | DMA address enable; a high level blocks decoding |
| hi_bank | input | 1 | Selects the upper register bank |
| addr | input | 3 | Slot index inside the bank |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data, also passed to the transfer neighbour |
| rdata | output | 8 | Read data, 0xFF when idle or undefined |
| prn_busy | input | 1 | Printer busy |
| prn_ack_n | input | 1 | Printer acknowledge, active low |
| prn_pe | input | 1 | Paper empty |
| prn_slct | input | 1 | Printer selected |
| prn_err_n | input | 1 | Printer error, active low |
| pd_in | input | 8 | Printer data bus as received |
| pd_out | output | 8 | Printer data bus value to drive |
| pd_oe | output | 1 | Printer data output enable |
| pd_dir | output | 1 | Direction indicator, 1 = input |
| line_ctl | output | 4 | Control register bits [3:0] |
| port_mode | output | 3 | Current mode field |
| xfer_rdata | input | 8 | Read data from the FIFO/EPP neighbour |
| xfer_wr | output | 1 | One-cycle write pulse to the neighbour |
| xfer_rd | output | 1 | One-cycle read pulse to the neighbour |
| xfer_code | output | 3 | Target port code of the active pulse |

## Verification
Read data and transfer pulses are combinational from the strobe and the stored state. They are due in the same cycle the strobe falls, so the bench samples them 2 ns after driving the strobe and before the next rising edge. A register write takes effect at the first rising edge that sees the write strobe low. It becomes visible to the next read and on `port_mode`, `line_ctl`, `pd_out`, `pd_dir` and `pd_oe` after that edge. A printer status change appears in the status byte one edge after the inputs move, so the bench waits one clock before reading it. Ignored writes are confirmed by reading the same slot back, or its aliased register in another mode.

// File: rtl/pp_pkg.sv
// Shared types for the parallel port register decoder.
// Assumes an 8-bit host data bus and a 3-bit mode field.
package pp_pkg;

    localparam int DW = 8;
    localparam int MW = 3;

    // Mode field encodings
    localparam logic [MW-1:0] M_SPP    = 3'b000;
    localparam logic [MW-1:0] M_BIDIR  = 3'b001;
    localparam logic [MW-1:0] M_PFIFO  = 3'b010;
    localparam logic [MW-1:0] M_ECP    = 3'b011;
    localparam logic [MW-1:0] M_EPP    = 3'b100;
    localparam logic [MW-1:0] M_TEST   = 3'b110;
    localparam logic [MW-1:0] M_CFG    = 3'b111;

    // Transfer port codes sent to the FIFO/EPP neighbour
    localparam logic [2:0] X_NONE     = 3'd0;
    localparam logic [2:0] X_ECP_CMD  = 3'd1;
    localparam logic [2:0] X_PFIFO    = 3'd2;
    localparam logic [2:0] X_ECP_DATA = 3'd3;
    localparam logic [2:0] X_TEST     = 3'd4;
    localparam logic [2:0] X_EPP_ADDR = 3'd5;
    localparam logic [2:0] X_EPP_DATA = 3'd6;

    typedef enum logic [2:0] {
        K_NONE, K_DATA, K_STAT, K_CTRL, K_ECR, K_CFGA, K_CFGB, K_XFER
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic       can_rd;
        logic       can_wr;
        logic [2:0] xcode;
    } slot_t;

endpackage

// File: rtl/pp_bus_front.sv
// Bus front end: qualifies the access window and turns the read and
// write strobes into single-cycle edge events.
// Assumes strobes are already synchronous to clk.
module pp_bus_front (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic aen,
    input  logic rd_n,
    input  logic wr_n,
    output logic sel,
    output logic rd_act,
    output logic rd_edge,
    output logic wr_edge
);
    logic rd_q;
    logic wr_q;

    // Remember the previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b1;
            wr_q <= 1'b1;
        end else begin
            rd_q <= rd_n;
            wr_q <= wr_n;
        end
    end

    // Decode window and strobe edges.
    always_comb begin
        sel     = !cs_n && !aen;
        rd_act  = sel && !rd_n;
        rd_edge = rd_act && rd_q;
        wr_edge = sel && !wr_n && wr_q;
    end
endmodule

// File: rtl/pp_addr_map.sv
// Address map: given mode, bank and slot index, names the target
// and whether it may be read or written. Purely combinational.
module pp_addr_map
    import pp_pkg::*;
(
    input  logic [MW-1:0] mode,
    input  logic          hi_bank,
    input  logic [2:0]    idx,
    output slot_t         slot
);
    // Per-mode slot lookup.
    always_comb begin
        slot = '{kind: K_NONE, can_rd: 1'b0, can_wr: 1'b0, xcode: X_NONE};
        if (!hi_bank) begin
            unique case (idx)
                3'd0: begin
                    if (mode == M_SPP || mode == M_BIDIR)
                        slot = '{K_DATA, 1'b1, 1'b1, X_NONE};
                    else if (mode == M_ECP)
                        slot = '{K_XFER, 1'b0, 1'b1, X_ECP_CMD};
                end
                3'd1: slot = '{K_STAT, 1'b1, 1'b0, X_NONE};
                3'd2: slot = '{K_CTRL, 1'b1, 1'b1, X_NONE};
                3'd3: begin
                    if (mode == M_EPP)
                        slot = '{K_XFER, 1'b1, 1'b1, X_EPP_ADDR};
                end
                default: begin
                    if (mode == M_EPP)
                        slot = '{K_XFER, 1'b1, 1'b1, X_EPP_DATA};
                end
            endcase
        end else begin
            unique case (idx)
                3'd0: begin
                    unique case (mode)
                        M_PFIFO: slot = '{K_XFER, 1'b0, 1'b1, X_PFIFO};
                        M_ECP:   slot = '{K_XFER, 1'b1, 1'b1, X_ECP_DATA};
                        M_TEST:  slot = '{K_XFER, 1'b1, 1'b1, X_TEST};
                        M_CFG:   slot = '{K_CFGA, 1'b1, 1'b0, X_NONE};
                        default: ;
                    endcase
                end
                3'd1: begin
                    if (mode == M_CFG)
                        slot = '{K_CFGB, 1'b1, 1'b1, X_NONE};
                end
                3'd2: slot = '{K_ECR, 1'b1, 1'b1, X_NONE};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pp_reg_bank.sv
// Register storage and read mux: data latch, status sample, control,
// extended control and configuration B. Also derives the data direction.
// Assumes wr_en is a single-cycle qualified write event.
module pp_reg_bank
    import pp_pkg::*;
#(
    parameter logic [DW-1:0] CFGA_VALUE = 8'h10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  kind_e         kind,
    input  logic [DW-1:0] wdata,
    input  logic [4:0]    stat_raw,
    input  logic [DW-1:0] pd_in,
    input  logic [DW-1:0] xfer_rdata,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] data_q,
    output logic [5:0]    ctl_q,
    output logic [MW-1:0] mode,
    output logic          dir_in
);
    localparam int ECR_LOW = DW - MW;

    logic [DW-1:0]      stat_q;
    logic [ECR_LOW-1:0] ecr_low_q;
    logic [DW-1:0]      cfgb_q;
    logic               bidir_mode;

    // Sample printer status once per clock into the status byte layout.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 8'h07;
        else        stat_q <= {~stat_raw[4], stat_raw[3:0], 3'b111};
    end

    // Host writes into the stored registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            ctl_q     <= '0;
            mode      <= M_SPP;
            ecr_low_q <= '0;
            cfgb_q    <= '0;
        end else if (wr_en) begin
            unique case (kind)
                K_DATA: data_q <= wdata;
                K_CTRL: ctl_q  <= wdata[5:0];
                K_ECR: begin
                    mode      <= wdata[DW-1 -: MW];
                    ecr_low_q <= wdata[ECR_LOW-1:0];
                end
                K_CFGB: cfgb_q <= wdata;
                default: ;
            endcase
        end
    end

    // Direction: input only in bidirectional-capable modes with bit 5 set.
    always_comb begin
        bidir_mode = !(mode == M_SPP || mode == M_PFIFO);
        dir_in     = bidir_mode && ctl_q[5];
    end

    // Read data selection.
    always_comb begin
        unique case (kind)
            K_DATA:  rd_val = dir_in ? pd_in : data_q;
            K_STAT:  rd_val = stat_q;
            K_CTRL:  rd_val = {2'b11, ctl_q};
            K_ECR:   rd_val = {mode, ecr_low_q};
            K_CFGA:  rd_val = CFGA_VALUE;
            K_CFGB:  rd_val = cfgb_q;
            K_XFER:  rd_val = xfer_rdata;
            default: rd_val = '1;
        endcase
    end
endmodule

// File: rtl/pport_regdec.sv
// Top of the multi-mode parallel port register decoder. Ties the bus
// front end, the mode-dependent address map and the register bank,
// and emits transfer pulses for FIFO and EPP slots.
// Assumes synchronous strobes and a synchronous active-low reset.
module pport_regdec
    import pp_pkg::*;
#(
    parameter logic [7:0] CFGA_VALUE = 8'h10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       aen,
    input  logic       hi_bank,
    input  logic [2:0] addr,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       prn_busy,
    input  logic       prn_ack_n,
    input  logic       prn_pe,
    input  logic       prn_slct,
    input  logic       prn_err_n,
    input  logic [7:0] pd_in,
    output logic [7:0] pd_out,
    output logic       pd_oe,
    output logic       pd_dir,
    output logic [3:0] line_ctl,
    output logic [2:0] port_mode,
    input  logic [7:0] xfer_rdata,
    output logic       xfer_wr,
    output logic       xfer_rd,
    output logic [2:0] xfer_code
);
    logic          sel, rd_act, rd_edge, wr_edge;
    slot_t         slot;
    logic [DW-1:0] rd_val, data_q;
    logic [5:0]    ctl_q;
    logic [MW-1:0] mode;
    logic          dir_in;
    logic          reg_wr;

    pp_bus_front u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .aen(aen),
        .rd_n(rd_n), .wr_n(wr_n), .sel(sel), .rd_act(rd_act),
        .rd_edge(rd_edge), .wr_edge(wr_edge)
    );

    pp_addr_map u_map (
        .mode(mode), .hi_bank(hi_bank), .idx(addr), .slot(slot)
    );

    pp_reg_bank #(.CFGA_VALUE(CFGA_VALUE)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .kind(slot.kind),
        .wdata(wdata),
        .stat_raw({prn_busy, prn_ack_n, prn_pe, prn_slct, prn_err_n}),
        .pd_in(pd_in), .xfer_rdata(xfer_rdata), .rd_val(rd_val),
        .data_q(data_q), .ctl_q(ctl_q), .mode(mode), .dir_in(dir_in)
    );

    // Qualify events and drive the outward signals.
    always_comb begin
        reg_wr    = wr_edge && slot.can_wr && slot.kind != K_XFER;
        xfer_wr   = wr_edge && slot.can_wr && slot.kind == K_XFER;
        xfer_rd   = rd_edge && slot.can_rd && slot.kind == K_XFER;
        xfer_code = (xfer_wr || xfer_rd) ? slot.xcode : X_NONE;
        rdata     = (rd_act && slot.can_rd) ? rd_val : 8'hFF;
        pd_out    = data_q;
        pd_dir    = dir_in;
        pd_oe     = !dir_in;
        line_ctl  = ctl_q[3:0];
        port_mode = mode;
    end
endmodule

// File: rtl/pport_regdec_chk.sv
// Assertion checker for pport_regdec, bound to every instance.
module pport_regdec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       aen,
    input logic       hi_bank,
    input logic [2:0] addr,
    input logic       rd_n,
    input logic       wr_n,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       pd_dir,
    input logic [2:0] port_mode,
    input logic       xfer_wr,
    input logic       xfer_rd,
    input logic [2:0] xfer_code
);
    a_r2_blocked_window: assert property (@(posedge clk) disable iff (!rst_n)
        (aen || cs_n) |-> (!xfer_wr && !xfer_rd && rdata == 8'hFF));

    a_r2_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> rdata == 8'hFF);

    a_r3_mode_follows_ecr: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !aen && hi_bank && addr == 3'd2 && !wr_n && $past(wr_n))
        |=> port_mode == $past(wdata[7:5]));

    a_r11_output_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (port_mode == 3'b000 || port_mode == 3'b010) |-> !pd_dir);

    a_r8_epp_codes_in_epp: assert property (@(posedge clk) disable iff (!rst_n)
        ((xfer_wr || xfer_rd) && xfer_code >= 3'd5) |-> port_mode == 3'b100);

    a_r12_write_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_wr |=> !xfer_wr);

    a_r12_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rd |=> !xfer_rd);

    a_r7_code_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_wr || xfer_rd) |-> xfer_code != 3'd0);
endmodule

bind pport_regdec pport_regdec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .aen(aen), .hi_bank(hi_bank),
    .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata),
    .pd_dir(pd_dir), .port_mode(port_mode), .xfer_wr(xfer_wr),
    .xfer_rd(xfer_rd), .xfer_code(xfer_code)
);

// File: tb/pport_regdec_bench.sv
module pport_regdec_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, aen = 1'b0, hi_bank = 1'b0;
    logic [2:0] addr = '0;
    logic       rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] wdata = '0, rdata;
    logic       prn_busy = 1'b0, prn_ack_n = 1'b1, prn_pe = 1'b0;
    logic       prn_slct = 1'b0, prn_err_n = 1'b1;
    logic [7:0] pd_in = '0, pd_out, xfer_rdata = '0;
    logic       pd_oe, pd_dir, xfer_wr, xfer_rd;
    logic [3:0] line_ctl;
    logic [2:0] port_mode, xfer_code;

    int n_chk = 0, n_fail = 0;
    logic       g_aen = 1'b0, g_csoff = 1'b0;
    logic [7:0] r_val;
    logic       r_pulse;
    logic [2:0] r_code;

    pport_regdec u_pport_regdec (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic hb, input logic [2:0] ix, input logic [7:0] d);
        @(negedge clk);
        cs_n = g_csoff; aen = g_aen; hi_bank = hb; addr = ix; wdata = d; wr_n = 1'b0;
        #2;
        r_pulse = xfer_wr; r_code = xfer_code;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1; aen = 1'b0;
    endtask

    task automatic bus_rd(input logic hb, input logic [2:0] ix);
        @(negedge clk);
        cs_n = g_csoff; aen = g_aen; hi_bank = hb; addr = ix; rd_n = 1'b0;
        #2;
        r_val = rdata; r_pulse = xfer_rd; r_code = xfer_code;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1; aen = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] m);
        bus_wr(1'b1, 3'd2, {m, 5'b0});
    endtask

    task automatic t_reset;
        #2;
        chk("R1 mode", {5'b0, port_mode}, 8'h00);
        chk("R1 oe/dir", {6'b0, pd_oe, pd_dir}, 8'h02);
        chk("R1 line_ctl", {4'b0, line_ctl}, 8'h00);
        chk("R1 pd_out", pd_out, 8'h00);
        bus_rd(1'b0, 3'd2); chk("R1 ctrl read", r_val, 8'hC0);
        bus_rd(1'b1, 3'd2); chk("R1 ecr read", r_val, 8'h00);
    endtask

    task automatic t_data;
        set_mode(3'b000);
        bus_wr(1'b0, 3'd0, 8'hA5);
        chk("R4 pd_out", pd_out, 8'hA5);
        bus_rd(1'b0, 3'd0); chk("R4 latch read", r_val, 8'hA5);
        set_mode(3'b001);
        pd_in = 8'h3C;
        bus_rd(1'b0, 3'd0); chk("R4 read latch dir out", r_val, 8'hA5);
        bus_wr(1'b0, 3'd2, 8'h20);
        chk("R11 bidir input", {6'b0, pd_oe, pd_dir}, 8'h01);
        bus_rd(1'b0, 3'd0); chk("R4 read pd_in", r_val, 8'h3C);
        bus_wr(1'b0, 3'd2, 8'h00);
    endtask

    task automatic t_status;
        prn_busy = 1'b1; prn_ack_n = 1'b0; prn_pe = 1'b1; prn_slct = 1'b0; prn_err_n = 1'b1;
        @(negedge clk);
        bus_rd(1'b0, 3'd1); chk("R5 status", r_val, 8'h2F);
        bus_wr(1'b0, 3'd1, 8'h00);
        bus_rd(1'b0, 3'd1); chk("R5 status write ignored", r_val, 8'h2F);
    endtask

    task automatic t_ctrl;
        bus_wr(1'b0, 3'd2, 8'h1A);
        chk("R6 line_ctl", {4'b0, line_ctl}, 8'h0A);
        bus_rd(1'b0, 3'd2); chk("R6 ctrl read", r_val, 8'hDA);
    endtask

    task automatic t_ecr;
        bus_wr(1'b1, 3'd2, 8'h75);
        chk("R3 port_mode", {5'b0, port_mode}, 8'h03);
        bus_rd(1'b1, 3'd2); chk("R3 ecr read", r_val, 8'h75);
    endtask

    task automatic t_fifo;
        set_mode(3'b011);
        xfer_rdata = 8'h5A;
        bus_wr(1'b0, 3'd0, 8'h11); chk("R7 ecp cmd write", {4'b0, r_pulse, r_code}, 8'h09);
        bus_rd(1'b0, 3'd0); chk("R7 ecp cmd read undefined", r_val, 8'hFF);
        chk("R7 ecp cmd read no pulse", {7'b0, r_pulse}, 8'h00);
        bus_wr(1'b1, 3'd0, 8'h22); chk("R7 ecp data write", {4'b0, r_pulse, r_code}, 8'h0B);
        bus_rd(1'b1, 3'd0); chk("R7 ecp data read", r_val, 8'h5A);
        chk("R7 ecp data read code", {4'b0, r_pulse, r_code}, 8'h0B);
        set_mode(3'b010);
        bus_wr(1'b1, 3'd0, 8'h33); chk("R7 pfifo write", {4'b0, r_pulse, r_code}, 8'h0A);
        bus_rd(1'b1, 3'd0); chk("R7 pfifo read undefined", {3'b0, r_pulse, 4'b0} | r_val, 8'hFF);
        chk("R7 pfifo read no pulse", {7'b0, r_pulse}, 8'h00);
        set_mode(3'b110);
        bus_rd(1'b1, 3'd0); chk("R7 test fifo read", {4'b0, r_pulse, r_code}, 8'h0C);
    endtask

    task automatic t_epp;
        set_mode(3'b100);
        xfer_rdata = 8'hC3;
        bus_wr(1'b0, 3'd3, 8'h44); chk("R8 epp addr write", {4'b0, r_pulse, r_code}, 8'h0D);
        bus_rd(1'b0, 3'd6); chk("R8 epp data read", r_val, 8'hC3);
        chk("R8 epp data code", {4'b0, r_pulse, r_code}, 8'h0E);
        bus_wr(1'b0, 3'd4, 8'h45); chk("R8 epp data write", {4'b0, r_pulse, r_code}, 8'h0E);
    endtask

    task automatic t_undef;
        set_mode(3'b000);
        bus_wr(1'b1, 3'd1, 8'h55);
        bus_rd(1'b1, 3'd1); chk("R10 upper slot1 mode 000", r_val, 8'hFF);
        bus_rd(1'b0, 3'd3); chk("R10 lower slot3 mode 000", {3'b0, r_pulse, 4'b0} | r_val, 8'hFF);
        chk("R10 no pulse", {7'b0, r_pulse}, 8'h00);
        bus_wr(1'b0, 3'd0, 8'h66);
        set_mode(3'b101);
        bus_wr(1'b0, 3'd0, 8'h11);
        chk("R10 mode 101 write ignored", pd_out, 8'h66);
        set_mode(3'b111);
        bus_rd(1'b1, 3'd1); chk("R10 cfgB untouched", r_val, 8'h00);
    endtask

    task automatic t_cfg;
        set_mode(3'b111);
        bus_rd(1'b1, 3'd0); chk("R9 cfgA read", r_val, 8'h10);
        bus_wr(1'b1, 3'd0, 8'hEE);
        bus_rd(1'b1, 3'd0); chk("R9 cfgA write ignored", r_val, 8'h10);
        bus_wr(1'b1, 3'd1, 8'h3C);
        bus_rd(1'b1, 3'd1); chk("R9 cfgB read", r_val, 8'h3C);
    endtask

    task automatic t_window;
        set_mode(3'b000);
        bus_wr(1'b0, 3'd2, 8'h05);
        g_aen = 1'b1;
        bus_wr(1'b0, 3'd2, 8'h0F);
        g_aen = 1'b0;
        chk("R2 aen blocks write", {4'b0, line_ctl}, 8'h05);
        g_csoff = 1'b1;
        bus_rd(1'b0, 3'd2); chk("R2 cs off read", r_val, 8'hFF);
        g_csoff = 1'b0;
    endtask

    task automatic t_dir;
        set_mode(3'b010);
        bus_wr(1'b0, 3'd2, 8'h20);
        chk("R11 mode 010 stays output", {6'b0, pd_oe, pd_dir}, 8'h02);
        set_mode(3'b011);
        chk("R11 mode 011 input", {6'b0, pd_oe, pd_dir}, 8'h01);
        set_mode(3'b000);
        chk("R11 mode 000 output", {6'b0, pd_oe, pd_dir}, 8'h02);
    endtask

    task automatic t_pulse;
        int cnt = 0;
        set_mode(3'b011);
        @(negedge clk);
        cs_n = 1'b0; hi_bank = 1'b1; addr = 3'd0; wr_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #2;
            if (xfer_wr) cnt++;
            @(negedge clk);
        end
        wr_n = 1'b1; cs_n = 1'b1;
        #2;
        chk("R12 one pulse per strobe", cnt[7:0], 8'd1);
        chk("R12 code idle", {5'b0, xfer_code}, 8'h00);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_data;
        t_status;
        t_ctrl;
        t_ecr;
        t_fifo;
        t_epp;
        t_undef;
        t_cfg;
        t_window;
        t_dir;
        t_pulse;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule